// File: doc/BRIEF.md
# Mesh Router Output-Port Selector

This block decides where a packet goes next inside one router of a two-dimensional mesh. When a header is presented, it compares the destination column and row with the router's own position. It then asks for exactly one of five outputs: toward lower X (west), toward higher X (east), toward lower Y (south), toward higher Y (north), or the attached processor (local).

By default the selection is fixed by position alone. All X travel finishes before any Y travel starts. Because of that ordering, no cycle of channel waits can form in the mesh. An `adaptive_en` input switches to a turn-restricted mode. In that mode any westward hop is still taken first, without exception. After that, the block may pick among the productive east, north and south outputs, using per-output congestion flags from the neighbouring links.

The request is registered, so it appears on the clock edge after the header is sampled. Cycles without a header give an all-zero request.

Top module: `mesh_route_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `port_req` is all zeros.
- R2: In a cycle where `hdr_valid` is low, `port_req` is all zeros after the next clock edge.
- R3: `port_req` bit positions are: bit 0 west, bit 1 east, bit 2 south, bit 3 north, bit 4 local. With `adaptive_en` low and `dst_x` below `own_x`, the request is west.
- R4: With `adaptive_en` low and `dst_x` above `own_x`, the request is east, whatever the Y coordinates are.
- R5: With `adaptive_en` low and `dst_x` equal to `own_x`, the request is south when `dst_y` is below `own_y` and north when `dst_y` is above it.
- R6: When both coordinates match the router's own, the request is local in either mode, whatever the congestion flags are.
- R7: With `adaptive_en` low, the `congested` flags have no effect on the request.
- R8: With `adaptive_en` high and `dst_x` below `own_x`, the request is west even when the west flag is set.
- R9: With `adaptive_en` high and `dst_x` not below `own_x`, the candidates are east if `dst_x` is above `own_x`, north if `dst_y` is above `own_y`, and south if `dst_y` is below `own_y`. The first candidate whose `congested` bit is clear wins, checked in the order east, north, south. `congested` uses the same bit positions as `port_req`.
- R10: With `adaptive_en` high, if every candidate is congested, the request equals the fixed-mode choice.
- R11: After the clock edge that samples `hdr_valid` high, `port_req` has exactly one bit set, and it holds the result for that header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | A header is presented this cycle |
| dst_x | input | X_W | Destination column |
| dst_y | input | Y_W | Destination row |
| own_x | input | X_W | This router's column |
| own_y | input | Y_W | This router's row |
| adaptive_en | input | 1 | 1 selects turn-restricted adaptive mode, 0 selects fixed X-then-Y |
| congested | input | 5 | Per-output congestion flags, same bit order as port_req |
| port_req | output | 5 | One-hot output request, registered |

## Verification
The hardest case to reach is the adaptive fallback. It needs a diagonal destination to the north-east or south-east, so that two candidates exist, together with congestion on each candidate but not on the others. Random coordinates seldom line up with the exact flag combinations that separate east-preferred, north or south taken, and full fallback. The stimulus therefore walks every congestion pattern for fixed diagonal and straight-line destinations. It then follows with random traffic in which the flags are often all set. The same patterns are replayed in fixed mode to show that the flags are ignored there.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;

    localparam int NUM_PORTS = 5;

    typedef enum logic [2:0] {
        DIR_WEST  = 3'd0,
        DIR_EAST  = 3'd1,
        DIR_SOUTH = 3'd2,
        DIR_NORTH = 3'd3,
        DIR_LOCAL = 3'd4
    } dir_e;

    typedef logic [NUM_PORTS-1:0] port_vec_t;

    // Sign summary of the destination-minus-own offsets.
    typedef struct packed {
        logic x_neg;
        logic x_pos;
        logic y_neg;
        logic y_pos;
    } heading_t;

    function automatic port_vec_t dir_to_vec(input dir_e d);
        port_vec_t v;
        v = '0;
        v[int'(d)] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/mesh_axis_offset.sv
module mesh_axis_offset #(
    parameter int W = 4
) (
    input  logic [W-1:0] dst,
    input  logic [W-1:0] own,
    output logic         neg,
    output logic         pos
);
    localparam int DW = W + 1;

    logic signed [DW-1:0] diff;

    always_comb begin
        diff = $signed({1'b0, dst}) - $signed({1'b0, own});
        neg  = diff[DW-1];
        pos  = !diff[DW-1] && (diff != '0);
    end
endmodule

// File: rtl/mesh_xy_select.sv
module mesh_xy_select
    import mesh_route_pkg::*;
(
    input  heading_t hd,
    output dir_e     dir
);
    always_comb begin
        if (hd.x_neg)      dir = DIR_WEST;
        else if (hd.x_pos) dir = DIR_EAST;
        else if (hd.y_neg) dir = DIR_SOUTH;
        else if (hd.y_pos) dir = DIR_NORTH;
        else               dir = DIR_LOCAL;
    end
endmodule

// File: rtl/mesh_wf_select.sv
module mesh_wf_select
    import mesh_route_pkg::*;
(
    input  heading_t  hd,
    input  port_vec_t congested,
    input  dir_e      xy_dir,
    output dir_e      dir
);
    logic east_ok, north_ok, south_ok;

    always_comb begin
        east_ok  = hd.x_pos && !congested[int'(DIR_EAST)];
        north_ok = hd.y_pos && !congested[int'(DIR_NORTH)];
        south_ok = hd.y_neg && !congested[int'(DIR_SOUTH)];
        if (hd.x_neg)                                dir = DIR_WEST;
        else if (!(hd.x_pos || hd.y_pos || hd.y_neg)) dir = DIR_LOCAL;
        else if (east_ok)                            dir = DIR_EAST;
        else if (north_ok)                           dir = DIR_NORTH;
        else if (south_ok)                           dir = DIR_SOUTH;
        else                                         dir = xy_dir;
    end
endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit
    import mesh_route_pkg::*;
#(
    parameter int X_W = 4,
    parameter int Y_W = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           hdr_valid,
    input  logic [X_W-1:0] dst_x,
    input  logic [Y_W-1:0] dst_y,
    input  logic [X_W-1:0] own_x,
    input  logic [Y_W-1:0] own_y,
    input  logic           adaptive_en,
    input  logic [4:0]     congested,
    output logic [4:0]     port_req
);
    heading_t  hd;
    dir_e      xy_dir;
    dir_e      wf_dir;
    dir_e      pick;
    port_vec_t req_q;

    mesh_axis_offset #(.W(X_W)) u_xoff (
        .dst(dst_x), .own(own_x), .neg(hd.x_neg), .pos(hd.x_pos)
    );

    mesh_axis_offset #(.W(Y_W)) u_yoff (
        .dst(dst_y), .own(own_y), .neg(hd.y_neg), .pos(hd.y_pos)
    );

    mesh_xy_select u_xy (.hd(hd), .dir(xy_dir));

    mesh_wf_select u_wf (
        .hd(hd), .congested(congested), .xy_dir(xy_dir), .dir(wf_dir)
    );

    always_comb pick = adaptive_en ? wf_dir : xy_dir;

    always_ff @(posedge clk) begin
        if (rst)            req_q <= '0;
        else if (hdr_valid) req_q <= dir_to_vec(pick);
        else                req_q <= '0;
    end

    assign port_req = req_q;
endmodule

// File: rtl/mesh_route_checker.sv
module mesh_route_checker #(
    parameter int X_W = 4,
    parameter int Y_W = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           hdr_valid,
    input logic [X_W-1:0] dst_x,
    input logic [Y_W-1:0] dst_y,
    input logic [X_W-1:0] own_x,
    input logic [Y_W-1:0] own_y,
    input logic           adaptive_en,
    input logic [4:0]     congested,
    input logic [4:0]     port_req
);
    p_onehot0_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(port_req));

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !hdr_valid |=> port_req == 5'b00000);

    p_single_req_r11: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |=> $countones(port_req) == 1);

    p_xy_west_r3: assert property (@(posedge clk) disable iff (rst)
        hdr_valid && !adaptive_en && (dst_x < own_x) |=> port_req == 5'b00001);

    p_xy_east_r4: assert property (@(posedge clk) disable iff (rst)
        hdr_valid && !adaptive_en && (dst_x > own_x) |=> port_req == 5'b00010);

    p_local_r6: assert property (@(posedge clk) disable iff (rst)
        hdr_valid && (dst_x == own_x) && (dst_y == own_y) |=> port_req == 5'b10000);

    p_west_first_r8: assert property (@(posedge clk) disable iff (rst)
        hdr_valid && adaptive_en && (dst_x < own_x) |=> port_req == 5'b00001);

    p_no_late_west_r9: assert property (@(posedge clk) disable iff (rst)
        hdr_valid && (dst_x >= own_x) |=> !port_req[0]);
endmodule

bind mesh_route_unit mesh_route_checker #(.X_W(X_W), .Y_W(Y_W)) u_route_chk (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid),
    .dst_x(dst_x), .dst_y(dst_y), .own_x(own_x), .own_y(own_y),
    .adaptive_en(adaptive_en), .congested(congested), .port_req(port_req)
);

// File: tb/mesh_route_unit_bench.sv
module mesh_route_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hdr_valid = 1'b0;
    logic [3:0] dst_x = '0, dst_y = '0, own_x = '0, own_y = '0;
    logic       adaptive_en = 1'b0;
    logic [4:0] congested = '0;
    logic [4:0] port_req;

    int         checks = 0;
    int         failures = 0;
    logic [4:0] exp_req = '0;
    string      exp_tag = "R1";

    always #2.5 clk = ~clk;

    mesh_route_unit u_mesh_route_unit (
        .clk(clk), .rst(rst), .hdr_valid(hdr_valid),
        .dst_x(dst_x), .dst_y(dst_y), .own_x(own_x), .own_y(own_y),
        .adaptive_en(adaptive_en), .congested(congested), .port_req(port_req)
    );

    task automatic model(input logic v, input int dx, input int dy, input logic m,
                         input logic [4:0] c, output logic [4:0] e, output string t);
        logic [4:0] xy;
        string      xt;
        if (dx < 0)      begin xy = 5'b00001; xt = "R3"; end
        else if (dx > 0) begin xy = 5'b00010; xt = "R4"; end
        else if (dy < 0) begin xy = 5'b00100; xt = "R5"; end
        else if (dy > 0) begin xy = 5'b01000; xt = "R5"; end
        else             begin xy = 5'b10000; xt = "R6"; end
        if (!v) begin
            e = 5'b0; t = "R2";
        end else if (dx == 0 && dy == 0) begin
            e = 5'b10000; t = "R6 R11";
        end else if (!m) begin
            e = xy; t = (c != 0) ? {xt, " R7 R11"} : {xt, " R11"};
        end else if (dx < 0) begin
            e = 5'b00001; t = "R8 R11";
        end else if (dx > 0 && !c[1]) begin
            e = 5'b00010; t = "R9 R11";
        end else if (dy > 0 && !c[3]) begin
            e = 5'b01000; t = "R9 R11";
        end else if (dy < 0 && !c[2]) begin
            e = 5'b00100; t = "R9 R11";
        end else begin
            e = xy; t = "R10 R11";
        end
    endtask

    task automatic compare_now();
        checks++;
        if (port_req !== exp_req) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", exp_tag, port_req, exp_req);
        end
    endtask

    task automatic step(input logic v, input logic [3:0] dx_, input logic [3:0] dy_,
                        input logic [3:0] ox, input logic [3:0] oy,
                        input logic m, input logic [4:0] c);
        @(negedge clk);
        compare_now();
        hdr_valid = v; dst_x = dx_; dst_y = dy_; own_x = ox; own_y = oy;
        adaptive_en = m; congested = c;
        model(v, int'(dx_) - int'(ox), int'(dy_) - int'(oy), m, c, exp_req, exp_tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state, header presented during reset must not show up
        hdr_valid = 1'b1; dst_x = 4'd9;
        repeat (3) begin
            @(negedge clk);
            exp_req = '0; exp_tag = "R1";
            compare_now();
        end
        rst = 1'b0; hdr_valid = 1'b0;
        exp_req = '0; exp_tag = "R1";
        // Fixed mode, straight lines and corners (R3 R4 R5 R6 R11)
        step(1, 4'd2,  4'd5, 4'd5, 4'd5, 0, 5'b0);
        step(1, 4'd9,  4'd1, 4'd5, 4'd5, 0, 5'b0);
        step(1, 4'd5,  4'd0, 4'd5, 4'd5, 0, 5'b0);
        step(1, 4'd5,  4'd15,4'd5, 4'd5, 0, 5'b0);
        step(1, 4'd5,  4'd5, 4'd5, 4'd5, 0, 5'b0);
        step(1, 4'd0,  4'd15,4'd15,4'd0, 0, 5'b0);
        step(1, 4'd15, 4'd0, 4'd0, 4'd15,0, 5'b0);
        step(0, 4'd15, 4'd0, 4'd0, 4'd15,0, 5'b0);   // R2
        // R7: flags ignored in fixed mode
        for (int c = 0; c < 32; c++) begin
            step(1, 4'd8, 4'd9, 4'd3, 4'd3, 0, 5'(c));
            step(1, 4'd3, 4'd1, 4'd3, 4'd3, 0, 5'(c));
        end
        // R6 R8 in adaptive mode under every flag pattern
        for (int c = 0; c < 32; c++) begin
            step(1, 4'd1, 4'd9, 4'd6, 4'd3, 1, 5'(c));
            step(1, 4'd6, 4'd3, 4'd6, 4'd3, 1, 5'(c));
        end
        // R9 R10: diagonal and straight candidates
        for (int c = 0; c < 32; c++) begin
            step(1, 4'd10, 4'd12, 4'd4, 4'd4, 1, 5'(c));
            step(1, 4'd10, 4'd1,  4'd4, 4'd4, 1, 5'(c));
            step(1, 4'd4,  4'd12, 4'd4, 4'd4, 1, 5'(c));
            step(1, 4'd4,  4'd0,  4'd4, 4'd4, 1, 5'(c));
            step(1, 4'd12, 4'd4,  4'd4, 4'd4, 1, 5'(c));
        end
        // Random traffic with idle gaps, flags often saturated
        for (int i = 0; i < 2000; i++) begin
            logic [4:0] cf;
            cf = ($urandom % 3 == 0) ? 5'b11111 : 5'($urandom);
            step(1'($urandom % 4 != 0), 4'($urandom), 4'($urandom),
                 4'($urandom), 4'($urandom), 1'($urandom), cf);
        end
        step(0, 4'd0, 4'd0, 4'd0, 4'd0, 0, 5'b0);
        @(negedge clk);
        compare_now();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule